// File: doc/BRIEF.md
# Cascaded Biquad Equalizer Engine

This block is a stereo parametric equalizer. Each audio channel passes through seven second-order IIR sections in series. Each section is computed in direct form I from five signed coefficients in 4.20 fixed point. A frame strobe delivers one left and one right 24-bit sample. A single shared multiplier then works through every product of both channels. It does five products per section, starting with all left sections and then all right sections. A one-cycle valid strobe presents the filtered pair.

Coefficients are loaded through a simple write port into a staging bank. The staged set becomes the working set only when a frame is accepted. Because of this, a frame is never computed with a coefficient set that is only partly rewritten. A bypass control, taken when a frame is accepted, returns the input pair unchanged on the next cycle and leaves the filter history alone. Reset puts every section into a unity pass-through response.

Top module: `eq_cascade`

## Requirements
- R1: After reset, busy and out_valid are low and every section of both channels holds b0 = 0x100000 (1.0) and zero for b1, b2, a1 and a2, so that a filtered frame returns its input unchanged.
- R2: Each section computes acc = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2, where x1/x2 are its previous two inputs and y1/y2 its previous two outputs. Coefficients are 24-bit two's complement with 20 fraction bits. The write port selects a coefficient with cfg_tap: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2. Writes with cfg_tap 5 to 7 are ignored.
- R3: A section output is (acc + 2^19) shifted right arithmetically by 20, saturated to the range −8388608 to 8388607.
- R4: The seven sections of a channel run in series. The output of section s is the input of section s+1, section 0 takes the channel input, and section 6 gives the channel output. Each section keeps its history across frames.
- R5: Left and right use separate coefficients and separate history. cfg_ch = 0 writes the left bank and cfg_ch = 1 writes the right bank.
- R6: A frame is accepted on a clock edge where in_valid is high and busy is low. A filtered frame holds busy high for exactly 70 cycles. out_valid is then high for one cycle, together with the filtered out_left and out_right, beginning 70 edges after the accepting edge.
- R7: in_valid while busy is high is ignored. It neither changes the results nor extends busy.
- R8: A coefficient write goes to the staging bank and is used from the next accepted frame onward. A write in the same cycle as an accepting edge is not used by that frame but by the following one.
- R9: With bypass high on the accepting edge, out_valid is high on the next cycle with out_left/out_right equal to the accepted inputs. busy stays low and no section history changes.
- R10: Writes with cfg_sec 7 or above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| bypass | input | 1 | Pass the frame through unchanged |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_ch | input | 1 | Channel select for the write, 0 left, 1 right |
| cfg_sec | input | 3 | Section index for the write |
| cfg_tap | input | 3 | Coefficient select for the write |
| cfg_data | input | 24 | Coefficient value, 4.20 signed |
| out_valid | output | 1 | One-cycle result strobe |
| out_left | output | 24 | Left result, signed |
| out_right | output | 24 | Right result, signed |
| busy | output | 1 | Filter computation in progress |

## Verification
A coefficient write and an accepted frame strobe can fall on the same clock edge. The bench provokes this by raising cfg_we and in_valid in the same cycle. It judges the outcome by comparing two frames against its model: the frame accepted on that edge must still use the old coefficient, and the frame after it must use the new one. A second collision is also exercised: a frame strobe that arrives while the block is busy. That strobe must be dropped without disturbing the pending result or the length of the busy window. Both are checked through out_valid timing and output values against a per-cycle behavioural model.

// File: rtl/eq_pkg.sv
package eq_pkg;
    localparam int unsigned NSEC_D = 7;
    localparam int unsigned DW_D   = 24;
    localparam int unsigned CW_D   = 24;
    localparam int unsigned FRAC_D = 20;
    localparam int unsigned NTAP   = 5;

    typedef enum logic [2:0] {
        TAP_B0 = 3'd0,
        TAP_B1 = 3'd1,
        TAP_B2 = 3'd2,
        TAP_A1 = 3'd3,
        TAP_A2 = 3'd4
    } tap_e;

    function automatic logic is_feedback(tap_e t);
        return (t == TAP_A1) || (t == TAP_A2);
    endfunction
endpackage

// File: rtl/eq_coef_bank.sv
module eq_coef_bank
    import eq_pkg::*;
#(
    parameter int unsigned NSEC = NSEC_D,
    parameter int unsigned CW   = CW_D,
    parameter int unsigned FRAC = FRAC_D,
    parameter int unsigned SW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_ch,
    input  logic [SW-1:0]        wr_sec,
    input  logic [2:0]           wr_tap,
    input  logic signed [CW-1:0] wr_data,
    input  logic                 commit,
    input  logic                 rd_ch,
    input  logic [SW-1:0]        rd_sec,
    input  tap_e                 rd_tap,
    output logic signed [CW-1:0] rd_coef
);
    localparam logic [CW-1:0] UNITY    = {{(CW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic [SW-1:0] SEC_LAST = SW'(NSEC - 1);

    logic signed [CW-1:0] stage_q [2][NSEC][NTAP];
    logic signed [CW-1:0] work_q  [2][NSEC][NTAP];

    // Staging bank takes writes at any time; working bank changes only on commit.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++)
                for (int s = 0; s < NSEC; s++)
                    for (int t = 0; t < NTAP; t++) begin
                        stage_q[c][s][t] <= (t == 0) ? UNITY : '0;
                        work_q[c][s][t]  <= (t == 0) ? UNITY : '0;
                    end
        end else begin
            if (commit)
                work_q <= stage_q;
            if (wr_en && (wr_sec <= SEC_LAST) && (wr_tap <= 3'd4))
                stage_q[wr_ch][wr_sec][wr_tap] <= wr_data;
        end
    end

    assign rd_coef = work_q[rd_ch][rd_sec][rd_tap];
endmodule

// File: rtl/eq_seq.sv
module eq_seq
    import eq_pkg::*;
#(
    parameter int unsigned NSEC = NSEC_D,
    parameter int unsigned SW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          ch,
    output logic [SW-1:0] sec,
    output tap_e          tap,
    output logic          sec_end,
    output logic          last
);
    localparam logic [SW-1:0] SEC_LAST = SW'(NSEC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ch   <= 1'b0;
            sec  <= '0;
            tap  <= TAP_B0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                ch   <= 1'b0;
                sec  <= '0;
                tap  <= TAP_B0;
            end
        end else if (tap == TAP_A2) begin
            tap <= TAP_B0;
            if (sec == SEC_LAST) begin
                sec <= '0;
                if (ch) busy <= 1'b0;
                else    ch   <= 1'b1;
            end else begin
                sec <= sec + 1'b1;
            end
        end else begin
            tap <= tap_e'(tap + 3'd1);
        end
    end

    assign sec_end = busy && (tap == TAP_A2);
    assign last    = sec_end && ch && (sec == SEC_LAST);
endmodule

// File: rtl/eq_mac.sv
module eq_mac
    import eq_pkg::*;
#(
    parameter int unsigned NSEC = NSEC_D,
    parameter int unsigned DW   = DW_D,
    parameter int unsigned CW   = CW_D,
    parameter int unsigned FRAC = FRAC_D,
    parameter int unsigned SW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    input  logic                 busy,
    input  logic                 ch,
    input  logic [SW-1:0]        sec,
    input  tap_e                 tap,
    input  logic                 sec_end,
    input  logic signed [CW-1:0] coef,
    output logic signed [DW-1:0] y_now,
    output logic signed [DW-1:0] res_l
);
    localparam int unsigned PW = DW + CW;
    localparam int unsigned AW = PW + 4;
    localparam logic [SW-1:0]        SEC_LAST = SW'(NSEC - 1);
    localparam logic signed [AW-1:0] HALF = {{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = ~MAXV;

    function automatic logic signed [DW-1:0] round_sat(input logic signed [AW-1:0] a);
        logic signed [AW-1:0] r;
        r = (a + HALF) >>> FRAC;
        if (r > MAXV)      return MAXV[DW-1:0];
        else if (r < MINV) return MINV[DW-1:0];
        else               return r[DW-1:0];
    endfunction

    logic signed [DW-1:0] x1_q [2][NSEC];
    logic signed [DW-1:0] x2_q [2][NSEC];
    logic signed [DW-1:0] y1_q [2][NSEC];
    logic signed [DW-1:0] y2_q [2][NSEC];
    logic signed [DW-1:0] xcur_q, rhold_q;
    logic signed [AW-1:0] acc_q, acc_n, base;
    logic signed [DW-1:0] opnd;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_x;

    always_comb begin
        unique case (tap)
            TAP_B0:  opnd = xcur_q;
            TAP_B1:  opnd = x1_q[ch][sec];
            TAP_B2:  opnd = x2_q[ch][sec];
            TAP_A1:  opnd = y1_q[ch][sec];
            default: opnd = y2_q[ch][sec];
        endcase
        prod   = coef * opnd;
        prod_x = {{(AW-PW){prod[PW-1]}}, prod};
        base   = (tap == TAP_B0) ? '0 : acc_q;
        acc_n  = is_feedback(tap) ? (base - prod_x) : (base + prod_x);
        y_now  = round_sat(acc_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++)
                for (int s = 0; s < NSEC; s++) begin
                    x1_q[c][s] <= '0;
                    x2_q[c][s] <= '0;
                    y1_q[c][s] <= '0;
                    y2_q[c][s] <= '0;
                end
            xcur_q  <= '0;
            rhold_q <= '0;
            acc_q   <= '0;
            res_l   <= '0;
        end else if (!busy) begin
            if (start) begin
                xcur_q  <= in_l;
                rhold_q <= in_r;
            end
        end else begin
            acc_q <= acc_n;
            if (sec_end) begin
                x2_q[ch][sec] <= x1_q[ch][sec];
                x1_q[ch][sec] <= xcur_q;
                y2_q[ch][sec] <= y1_q[ch][sec];
                y1_q[ch][sec] <= y_now;
                if (sec == SEC_LAST) begin
                    if (!ch) begin
                        res_l  <= y_now;
                        xcur_q <= rhold_q;
                    end
                end else begin
                    xcur_q <= y_now;
                end
            end
        end
    end
endmodule

// File: rtl/eq_cascade.sv
module eq_cascade
    import eq_pkg::*;
#(
    parameter int unsigned NSEC = NSEC_D,
    parameter int unsigned DW   = DW_D,
    parameter int unsigned CW   = CW_D,
    parameter int unsigned FRAC = FRAC_D
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          in_valid,
    input  logic signed [DW-1:0]                          in_left,
    input  logic signed [DW-1:0]                          in_right,
    input  logic                                          bypass,
    input  logic                                          cfg_we,
    input  logic                                          cfg_ch,
    input  logic [((NSEC > 1) ? $clog2(NSEC) : 1)-1:0]    cfg_sec,
    input  logic [2:0]                                    cfg_tap,
    input  logic signed [CW-1:0]                          cfg_data,
    output logic                                          out_valid,
    output logic signed [DW-1:0]                          out_left,
    output logic signed [DW-1:0]                          out_right,
    output logic                                          busy
);
    localparam int unsigned SW = (NSEC > 1) ? $clog2(NSEC) : 1;

    logic                 accept, start;
    logic                 s_ch, s_sec_end, s_last;
    logic [SW-1:0]        s_sec;
    tap_e                 s_tap;
    logic signed [CW-1:0] coef;
    logic signed [DW-1:0] y_now, res_l;

    assign accept = in_valid && !busy;
    assign start  = accept && !bypass;

    eq_coef_bank #(.NSEC(NSEC), .CW(CW), .FRAC(FRAC), .SW(SW)) bank_i (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_ch(cfg_ch), .wr_sec(cfg_sec), .wr_tap(cfg_tap), .wr_data(cfg_data),
        .commit(accept),
        .rd_ch(s_ch), .rd_sec(s_sec), .rd_tap(s_tap), .rd_coef(coef)
    );

    eq_seq #(.NSEC(NSEC), .SW(SW)) seq_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .ch(s_ch), .sec(s_sec), .tap(s_tap), .sec_end(s_sec_end), .last(s_last)
    );

    eq_mac #(.NSEC(NSEC), .DW(DW), .CW(CW), .FRAC(FRAC), .SW(SW)) mac_i (
        .clk(clk), .rst(rst), .start(start), .in_l(in_left), .in_r(in_right),
        .busy(busy), .ch(s_ch), .sec(s_sec), .tap(s_tap), .sec_end(s_sec_end),
        .coef(coef), .y_now(y_now), .res_l(res_l)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= 1'b0;
            if (accept && bypass) begin
                out_valid <= 1'b1;
                out_left  <= in_left;
                out_right <= in_right;
            end else if (s_last) begin
                out_valid <= 1'b1;
                out_left  <= res_l;
                out_right <= y_now;
            end
        end
    end
endmodule

// File: rtl/eq_cascade_chk.sv
module eq_cascade_chk #(
    parameter int unsigned NSEC = 7,
    parameter int unsigned DW   = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 bypass,
    input logic                 busy,
    input logic                 out_valid,
    input logic signed [DW-1:0] in_left,
    input logic signed [DW-1:0] in_right,
    input logic signed [DW-1:0] out_left,
    input logic signed [DW-1:0] out_right
);
    localparam int unsigned LAT = NSEC * 5 * 2;
    localparam int unsigned CNW = $clog2(LAT + 1) + 1;

    logic [CNW-1:0] cnt;
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (busy) cnt <= cnt + 1'b1;
        else           cnt <= '0;
    end

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !out_valid));

    a_r6_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && !bypass) |=> busy);

    a_r6_no_valid_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !out_valid);

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (out_valid && cnt == CNW'(LAT)));

    a_r7_busy_held: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt < CNW'(LAT - 1)) |=> busy);

    a_r9_bypass_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && bypass) |=>
        (out_valid && !busy && out_left == $past(in_left) && out_right == $past(in_right)));
endmodule

bind eq_cascade eq_cascade_chk #(.NSEC(NSEC), .DW(DW)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .bypass(bypass), .busy(busy),
    .out_valid(out_valid), .in_left(in_left), .in_right(in_right),
    .out_left(out_left), .out_right(out_right)
);

// File: tb/eq_cascade_tb.sv
`timescale 1ns/1ps
module eq_cascade_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, bypass = 1'b0, cfg_we = 1'b0, cfg_ch = 1'b0;
    logic signed [23:0] in_left = '0, in_right = '0, cfg_data = '0;
    logic [2:0] cfg_sec = '0, cfg_tap = '0;
    logic out_valid, busy;
    logic signed [23:0] out_left, out_right;

    always #10 clk = ~clk;

    eq_cascade dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .bypass(bypass), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sec(cfg_sec),
        .cfg_tap(cfg_tap), .cfg_data(cfg_data), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .busy(busy)
    );

    int n_chk = 0, n_bad = 0;
    string cur_tag = "R1";

    // behavioural reference
    longint stg[2][7][5];
    longint wrk[2][7][5];
    longint hx1[2][7], hx2[2][7], hy1[2][7], hy2[2][7];
    longint m_l = 0, m_r = 0, p_l = 0, p_r = 0;
    int     m_left = 0;
    bit     m_valid = 0, m_busy = 0;

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint clamp(input longint a);
        longint r;
        r = (a + 64'sd524288) >>> 20;
        if (r > 64'sd8388607)  r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r;
    endfunction

    function automatic longint run_ch(input int c, input longint xin);
        longint x, acc, y;
        x = xin;
        for (int s = 0; s < 7; s++) begin
            acc = wrk[c][s][0]*x + wrk[c][s][1]*hx1[c][s] + wrk[c][s][2]*hx2[c][s]
                - wrk[c][s][3]*hy1[c][s] - wrk[c][s][4]*hy2[c][s];
            y = clamp(acc);
            hx2[c][s] = hx1[c][s]; hx1[c][s] = x;
            hy2[c][s] = hy1[c][s]; hy1[c][s] = y;
            x = y;
        end
        return x;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 7; s++) begin
                for (int t = 0; t < 5; t++) begin
                    stg[c][s][t] = (t == 0) ? 64'sd1048576 : 0;
                    wrk[c][s][t] = stg[c][s][t];
                end
                hx1[c][s] = 0; hx2[c][s] = 0; hy1[c][s] = 0; hy2[c][s] = 0;
            end
        m_left = 0; m_valid = 0; m_busy = 0;
    endtask

    initial model_reset();

    // compare on every clock, then advance the model over the coming edge
    always @(negedge clk) begin
        n_chk++;
        if (out_valid !== m_valid) begin
            n_bad++;
            $display("FAIL R6 out_valid actual=%b expected=%b t=%0t", out_valid, m_valid, $time);
        end
        n_chk++;
        if (busy !== m_busy) begin
            n_bad++;
            $display("FAIL R7 busy actual=%b expected=%b t=%0t", busy, m_busy, $time);
        end
        if (m_valid) begin
            n_chk++;
            if (longint'(out_left) != m_l || longint'(out_right) != m_r) begin
                n_bad++;
                $display("FAIL %s out actual=%0d/%0d expected=%0d/%0d",
                         cur_tag, out_left, out_right, m_l, m_r);
            end
        end
        if (rst) begin
            model_reset();
        end else begin
            m_valid = 0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin m_valid = 1; m_l = p_l; m_r = p_r; end
            end else if (in_valid) begin
                wrk = stg;
                if (bypass) begin
                    m_valid = 1; m_l = sx(in_left); m_r = sx(in_right);
                end else begin
                    p_l = run_ch(0, sx(in_left));
                    p_r = run_ch(1, sx(in_right));
                    m_left = 70;
                end
            end
            if (cfg_we && cfg_sec < 3'd7 && cfg_tap < 3'd5)
                stg[cfg_ch][cfg_sec][cfg_tap] = sx(cfg_data);
            m_busy = (m_left > 0);
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic wr(input bit c, input logic [2:0] s, input logic [2:0] t, input logic [23:0] d);
        @(posedge clk); #2;
        cfg_we = 1; cfg_ch = c; cfg_sec = s; cfg_tap = t; cfg_data = d;
        @(posedge clk); #2;
        cfg_we = 0;
    endtask

    task automatic frame(input logic [23:0] l, input logic [23:0] r, input bit byp);
        @(posedge clk); #2;
        in_valid = 1; in_left = l; in_right = r; bypass = byp;
        @(posedge clk); #2;
        in_valid = 0; bypass = 0;
        repeat (72) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk); #2;
        rst = 0;
        @(negedge clk);
        n_chk++;
        if (busy !== 1'b0 || out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 idle actual=%b%b expected=00", busy, out_valid);
        end

        cur_tag = "R1 unity";
        frame(24'h123456, 24'hF00001, 0);
        frame(24'h800000, 24'h7FFFFF, 0);

        cur_tag = "R2 feedforward";
        wr(0, 0, 0, 24'h080000);           // b0 = 0.5
        wr(0, 0, 1, 24'h040000);           // b1 = 0.25
        wr(0, 3, 2, 24'hFC0000);           // b2 = -0.25
        frame(24'h100000, 24'h000100, 0);
        frame(24'h0FFFFF, 24'h000200, 0);
        cur_tag = "R4 history";
        frame(24'h000000, 24'h000000, 0);
        frame(24'hF00000, 24'h000003, 0);

        cur_tag = "R5 right bank";
        wr(1, 0, 0, 24'h200000);           // right b0 = 2.0
        wr(1, 1, 3, 24'hF80000);           // right a1 = -0.5
        wr(0, 2, 4, 24'h020000);           // left a2 = 0.125
        frame(24'h010001, 24'h100000, 0);
        frame(24'h000000, 24'h000000, 0);

        cur_tag = "R3 saturate";
        wr(1, 2, 0, 24'h7FFFFF);           // right sec2 b0 near 8.0
        frame(24'h000333, 24'h300000, 0);
        frame(24'h000001, 24'hC00000, 0);
        cur_tag = "R3 rounding";
        wr(0, 5, 0, 24'h000003);           // tiny gain, result decided by rounding
        frame(24'h055555, 24'h000007, 0);
        frame(24'hFAAAAB, 24'h000000, 0);

        cur_tag = "R7 strobe while busy";
        @(posedge clk); #2; in_valid = 1; in_left = 24'h001000; in_right = 24'h002000;
        @(posedge clk); #2; in_valid = 0;
        repeat (20) @(posedge clk); #2;
        in_valid = 1; in_left = 24'h7FFFFF; in_right = 24'h7FFFFF;
        @(posedge clk); #2; in_valid = 0;
        repeat (60) @(posedge clk);

        cur_tag = "R8 write while busy";
        @(posedge clk); #2; in_valid = 1; in_left = 24'h020000; in_right = 24'h030000;
        @(posedge clk); #2; in_valid = 0;
        cfg_we = 1; cfg_ch = 0; cfg_sec = 6; cfg_tap = 0; cfg_data = 24'h180000;
        @(posedge clk); #2; cfg_we = 0;
        repeat (72) @(posedge clk);
        frame(24'h020000, 24'h030000, 0);

        cur_tag = "R8 same-cycle write";
        @(posedge clk); #2;
        in_valid = 1; in_left = 24'h040000; in_right = 24'h040000;
        cfg_we = 1; cfg_ch = 1; cfg_sec = 6; cfg_tap = 0; cfg_data = 24'h040000;
        @(posedge clk); #2; in_valid = 0; cfg_we = 0;
        repeat (72) @(posedge clk);
        frame(24'h040000, 24'h040000, 0);

        cur_tag = "R9 bypass";
        frame(24'h7ABCDE, 24'h812345, 1);
        frame(24'h000010, 24'hFFFFF0, 1);
        cur_tag = "R9 history kept";
        frame(24'h001234, 24'h004321, 0);

        cur_tag = "R10 bad section";
        wr(0, 7, 0, 24'h7FFFFF);
        cur_tag = "R2 bad tap";
        wr(1, 0, 5, 24'h7FFFFF);
        wr(1, 0, 7, 24'h7FFFFF);
        frame(24'h000800, 24'h000800, 0);
        cur_tag = "R10 R2 after ignored writes";
        frame(24'h100000, 24'hF00000, 0);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule